// File: doc/BRIEF.md
# DMA Channel Address Register Set

This block keeps the 16-bit base and current address of every channel of a legacy-style eight-channel DMA controller. Software reaches each channel's address through an 8-bit I/O port. A write loads the base register and the current register together. A read returns only the current register. Each 16-bit value is moved as two byte accesses. A byte-pointer flip-flop decides which byte each access uses. There is one such flip-flop for channels 0-3 and a separate one for channels 4-7. Each group has its own clear-pointer port and master-clear port, and both return the pointer to the low byte.

The transfer side names a channel and pulses `xferValid` once per transfer. The current address then moves by one, up or down, as that channel's mode input selects. At terminal count, a channel in auto-initialize mode instead copies its base address back into its current address. The block also gives the memory address of the channel that `xferCh` selects. For the word channels 5-7 this address is the current address shifted left by one bit.

Top module: `dma_addr_regs`

## Requirements
- R1: The address port of channel n is I/O offset 2*n for channels 0-3 and C0h+4*(n-4) for channels 4-7 (00h, 02h, 04h, 06h, C0h, C4h, C8h, CCh).
- R2: A write to a channel's address port places the data byte into the same byte (low when the group pointer is 0, high when it is 1) of both the base and the current register.
- R3: A read of a channel's address port returns the selected byte of the current register, so a value changed by stepping is visible and the base value is not.
- R4: Each group pointer is 0 (low byte) after reset. It toggles on every read or write of an address port in its own group and is unaffected by accesses to the other group.
- R5: A write to the clear-pointer port of a group (0Ch for channels 0-3, D8h for channels 4-7) sets that group's pointer to 0.
- R6: A write to the master-clear port of a group (0Dh for channels 0-3, DAh for channels 4-7) sets that group's pointer to 0.
- R7: Without a terminal count reload, a transfer on channel c adds one to its current address when modeDecr[c] is 0 and subtracts one when it is 1, wrapping modulo 2^16.
- R8: A transfer with xferTc high on a channel whose modeAutoInit bit is 1 loads the current address from the base address. With the bit at 0, the transfer steps as in R7.
- R9: memAddr is {current, 1'b0} when xferCh is 5, 6 or 7 and {1'b0, current} when xferCh is 0 to 4, for the channel that xferCh selects.
- R10: When an I/O write and a transfer hit the same channel in the same cycle, the write takes effect, the other byte of the current address keeps its previous value, and the step is dropped.
- R11: A read of any offset that is not an address port returns 00h and leaves both pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset of the byte pointers |
| ioAddr | input | 8 | I/O offset |
| ioWrData | input | 8 | I/O write byte |
| ioWr | input | 1 | I/O write strobe, one cycle per access |
| ioRd | input | 1 | I/O read strobe, one cycle per access |
| ioRdData | output | 8 | Read byte, combinational while ioRd is high |
| xferValid | input | 1 | One transfer completed on xferCh |
| xferCh | input | 3 | Channel of the transfer, also selects memAddr |
| xferTc | input | 1 | Terminal count reached with this transfer |
| modeDecr | input | 8 | Per channel: 1 counts down, 0 counts up |
| modeAutoInit | input | 8 | Per channel: reload from base at terminal count |
| memAddr | output | 17 | Memory address of the selected channel |

## Verification
Read data is combinational. The bench drives each read at a falling edge and samples `ioRdData` just before the next rising edge, which is the edge that toggles the pointer. Register writes, pointer clears and transfer steps take effect at the first rising edge after they are driven. Their results are therefore read back through the I/O port or through `memAddr` at the following falling edge or later, never in the driving cycle. Some checks depend on the pointer position, such as those for group independence, clearing and non-address reads. Those checks read a register whose two bytes differ, so the returned value shows which byte the pointer selected.

// File: rtl/dmaAddrPkg.sv
package dmaAddrPkg;
  localparam int CH_COUNT = 8;
  localparam int CH_BITS = $clog2(CH_COUNT);
  localparam int ADDR_W = 16;
  localparam int GRP_SIZE = CH_COUNT / 2;
  localparam int WORD_CH_FIRST = 5;
  localparam logic [7:0] UP_PORT_BASE = 8'hC0;
  localparam logic [7:0] LO_CLR_PORT = 8'h0C;
  localparam logic [7:0] LO_MCLR_PORT = 8'h0D;
  localparam logic [7:0] UP_CLR_PORT = 8'hD8;
  localparam logic [7:0] UP_MCLR_PORT = 8'hDA;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic [CH_BITS-1:0] ch;
    logic hiByte;
  } ioStrobe_t;

  function automatic logic [7:0] portOf(input int n);
    if (n < GRP_SIZE) return 8'(2 * n);
    return 8'(int'(UP_PORT_BASE) + 4 * (n - GRP_SIZE));
  endfunction
endpackage

// File: rtl/dmaAddrCtrl.sv
module dmaAddrCtrl
  import dmaAddrPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic [7:0] ioAddr,
  input  logic ioWr,
  input  logic ioRd,
  output ioStrobe_t strobe
);
  logic hit;
  logic [CH_BITS-1:0] hitCh;
  logic grpUp;
  logic [1:0] ptrHi;
  logic clrLo, clrUp;

  always_comb begin
    hit = 1'b0;
    hitCh = '0;
    for (int n = 0; n < CH_COUNT; n++) begin
      if (ioAddr == portOf(n)) begin
        hit = 1'b1;
        hitCh = CH_BITS'(n);
      end
    end
  end

  assign grpUp = hitCh[CH_BITS-1];
  assign clrLo = ioWr && (ioAddr == LO_CLR_PORT || ioAddr == LO_MCLR_PORT);
  assign clrUp = ioWr && (ioAddr == UP_CLR_PORT || ioAddr == UP_MCLR_PORT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrHi <= 2'b00;
    end else begin
      if (clrLo) ptrHi[0] <= 1'b0;
      else if (hit && (ioWr || ioRd) && !grpUp) ptrHi[0] <= ~ptrHi[0];
      if (clrUp) ptrHi[1] <= 1'b0;
      else if (hit && (ioWr || ioRd) && grpUp) ptrHi[1] <= ~ptrHi[1];
    end
  end

  assign strobe.wrEn = hit && ioWr;
  assign strobe.rdEn = hit && ioRd;
  assign strobe.ch = hitCh;
  assign strobe.hiByte = ptrHi[grpUp];

  assert_clear_lo_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == LO_CLR_PORT) |=> !ptrHi[0]);
  assert_clear_up_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == UP_CLR_PORT) |=> !ptrHi[1]);
  assert_master_up_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == UP_MCLR_PORT) |=> !ptrHi[1]);
  assert_toggle_up_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.wrEn || strobe.rdEn) && strobe.ch[CH_BITS-1] && !clrUp)
      |=> (ptrHi[1] != $past(ptrHi[1])) && (ptrHi[0] == $past(ptrHi[0])));
endmodule

// File: rtl/dmaAddrPath.sv
module dmaAddrPath
  import dmaAddrPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  ioStrobe_t strobe,
  input  logic [7:0] ioWrData,
  output logic [7:0] ioRdData,
  input  logic xferValid,
  input  logic [CH_BITS-1:0] xferCh,
  input  logic xferTc,
  input  logic [CH_COUNT-1:0] modeDecr,
  input  logic [CH_COUNT-1:0] modeAutoInit,
  output logic [ADDR_W:0] memAddr
);
  logic [ADDR_W-1:0] baseAddr [CH_COUNT];
  logic [ADDR_W-1:0] curAddr [CH_COUNT];

  always_ff @(posedge clk) begin
    for (int g = 0; g < CH_COUNT; g++) begin
      if (strobe.wrEn && strobe.ch == CH_BITS'(g)) begin
        if (strobe.hiByte) begin
          baseAddr[g][15:8] <= ioWrData;
          curAddr[g][15:8] <= ioWrData;
        end else begin
          baseAddr[g][7:0] <= ioWrData;
          curAddr[g][7:0] <= ioWrData;
        end
      end else if (xferValid && xferCh == CH_BITS'(g)) begin
        if (xferTc && modeAutoInit[g]) curAddr[g] <= baseAddr[g];
        else if (modeDecr[g]) curAddr[g] <= curAddr[g] - 1'b1;
        else curAddr[g] <= curAddr[g] + 1'b1;
      end
    end
  end

  assign ioRdData = !strobe.rdEn ? 8'h00 :
                    strobe.hiByte ? curAddr[strobe.ch][15:8] : curAddr[strobe.ch][7:0];

  generate
    if (WORD_CH_FIRST < CH_COUNT) begin : g_wordShift
      assign memAddr = (int'(xferCh) >= WORD_CH_FIRST) ? {curAddr[xferCh], 1'b0}
                                                       : {1'b0, curAddr[xferCh]};
    end else begin : g_byteOnly
      assign memAddr = {1'b0, curAddr[xferCh]};
    end
  endgenerate

  assert_write_both_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.hiByte) |=>
      baseAddr[$past(strobe.ch)][7:0] == $past(ioWrData) &&
      curAddr[$past(strobe.ch)][7:0] == $past(ioWrData));
  assert_step_up_R7: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && !xferTc && !modeDecr[xferCh] && !(strobe.wrEn && strobe.ch == xferCh))
      |=> curAddr[$past(xferCh)] == $past(curAddr[xferCh]) + 16'd1);
  assert_reload_R8: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && xferTc && modeAutoInit[xferCh] && !(strobe.wrEn && strobe.ch == xferCh))
      |=> curAddr[$past(xferCh)] == $past(baseAddr[xferCh]));
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && strobe.wrEn && strobe.ch == xferCh && strobe.hiByte)
      |=> curAddr[$past(xferCh)][7:0] == $past(curAddr[xferCh][7:0]));
endmodule

// File: rtl/dma_addr_regs.sv
module dma_addr_regs
  import dmaAddrPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic [7:0] ioAddr,
  input  logic [7:0] ioWrData,
  input  logic ioWr,
  input  logic ioRd,
  output logic [7:0] ioRdData,
  input  logic xferValid,
  input  logic [CH_BITS-1:0] xferCh,
  input  logic xferTc,
  input  logic [CH_COUNT-1:0] modeDecr,
  input  logic [CH_COUNT-1:0] modeAutoInit,
  output logic [ADDR_W:0] memAddr
);
  ioStrobe_t strobe;

  dmaAddrCtrl uCtrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd), .strobe(strobe)
  );

  dmaAddrPath uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .xferValid(xferValid), .xferCh(xferCh), .xferTc(xferTc),
    .modeDecr(modeDecr), .modeAutoInit(modeAutoInit), .memAddr(memAddr)
  );
endmodule

// File: tb/sim_dma_addr_regs.sv
module sim_dma_addr_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] ioAddr = '0, ioWrData = '0, ioRdData;
  logic ioWr = 1'b0, ioRd = 1'b0;
  logic xferValid = 1'b0, xferTc = 1'b0;
  logic [2:0] xferCh = '0;
  logic [7:0] modeDecr = '0, modeAutoInit = '0;
  logic [16:0] memAddr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_addr_regs u0 (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr), .ioRd(ioRd),
    .ioRdData(ioRdData), .xferValid(xferValid), .xferCh(xferCh), .xferTc(xferTc),
    .modeDecr(modeDecr), .modeAutoInit(modeAutoInit), .memAddr(memAddr)
  );

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic ioRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    #4 d = ioRdData;
    @(negedge clk);
    ioRd = 1'b0;
  endtask

  function automatic logic [7:0] clrFor(input logic [7:0] a);
    return (a >= 8'hC0) ? 8'hD8 : 8'h0C;
  endfunction

  task automatic write16(input logic [7:0] a, input logic [15:0] v);
    ioWrite(clrFor(a), 8'h00);
    ioWrite(a, v[7:0]);
    ioWrite(a, v[15:8]);
  endtask

  task automatic read16(input logic [7:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    ioWrite(clrFor(a), 8'h00);
    ioRead(a, lo);
    ioRead(a, hi);
    v = {hi, lo};
  endtask

  task automatic step(input logic [2:0] ch, input logic tc);
    @(negedge clk);
    xferCh = ch; xferTc = tc; xferValid = 1'b1;
    @(negedge clk);
    xferValid = 1'b0; xferTc = 1'b0;
  endtask

  function automatic logic [7:0] portOfCh(input int n);
    return (n < 4) ? 8'(2 * n) : 8'(8'hC0 + 4 * (n - 4));
  endfunction

  task automatic testResetDecode();
    logic [15:0] v;
    // R4: pointer starts low, so the first write after reset lands in the low byte.
    ioWrite(8'h00, 8'h10);
    ioWrite(8'h00, 8'hA0);
    for (int n = 1; n < 8; n++) begin
      ioWrite(portOfCh(n), 8'(8'h10 + n));
      ioWrite(portOfCh(n), 8'(8'hA0 + n));
    end
    for (int n = 0; n < 8; n++) begin
      read16(portOfCh(n), v);
      check($sformatf("R1/R2 ch%0d", n), {1'b0, v}, {1'b0, 8'(8'hA0 + n), 8'(8'h10 + n)});
    end
  endtask

  task automatic testGroups();
    logic [7:0] d;
    ioWrite(8'h0C, 8'h00);
    ioWrite(8'hD8, 8'h00);
    ioRead(8'h00, d);
    ioRead(8'hC4, d);
    check("R4 upper ptr independent", {9'd0, d}, 17'h15);
    ioRead(8'h02, d);
    check("R4 lower ptr toggled", {9'd0, d}, 17'hA1);
  endtask

  task automatic testClears();
    logic [7:0] d;
    ioWrite(8'hD8, 8'h00);
    ioRead(8'hC8, d);
    ioWrite(8'hD8, 8'h00);
    ioRead(8'hC8, d);
    check("R5 upper clear", {9'd0, d}, 17'h16);
    ioWrite(8'hDA, 8'h00);
    ioRead(8'hC8, d);
    check("R6 upper master clear", {9'd0, d}, 17'h16);
    ioWrite(8'h0C, 8'h00);
    ioRead(8'h04, d);
    ioWrite(8'h0C, 8'h00);
    ioRead(8'h04, d);
    check("R5 lower clear", {9'd0, d}, 17'h12);
    ioWrite(8'h0D, 8'h00);
    ioRead(8'h04, d);
    check("R6 lower master clear", {9'd0, d}, 17'h12);
  endtask

  task automatic testNonAddr();
    logic [7:0] d;
    ioWrite(8'hD8, 8'h00);
    ioRead(8'h08, d);
    check("R11 non-address read data", {9'd0, d}, 17'h0);
    ioRead(8'hC2, d);
    ioRead(8'hCC, d);
    check("R11 pointer unchanged", {9'd0, d}, 17'h17);
  endtask

  task automatic testStep();
    logic [15:0] v;
    modeDecr = '0;
    write16(8'h02, 16'hFFFE);
    step(3'd1, 1'b0);
    step(3'd1, 1'b0);
    read16(8'h02, v);
    check("R3/R7 increment wrap", {1'b0, v}, 17'h0000);
    modeDecr[1] = 1'b1;
    step(3'd1, 1'b0);
    read16(8'h02, v);
    check("R7 decrement wrap", {1'b0, v}, 17'hFFFF);
    modeDecr[1] = 1'b0;
  endtask

  task automatic testAutoInit();
    logic [15:0] v;
    write16(8'hC4, 16'h8001);
    modeAutoInit[5] = 1'b1;
    step(3'd5, 1'b0);
    read16(8'hC4, v);
    check("R3 read shows stepped value", {1'b0, v}, 17'h8002);
    step(3'd5, 1'b1);
    read16(8'hC4, v);
    check("R8 reload at terminal count", {1'b0, v}, 17'h8001);
    @(negedge clk); xferCh = 3'd5; #1;
    check("R9 word channel shift", memAddr, 17'h10002);
    modeAutoInit[5] = 1'b0;
    step(3'd5, 1'b1);
    read16(8'hC4, v);
    check("R8 no reload without auto-init", {1'b0, v}, 17'h8002);
    write16(8'h04, 16'h8000);
    @(negedge clk); xferCh = 3'd2; #1;
    check("R9 byte channel no shift", memAddr, 17'h08000);
    write16(8'hC0, 16'hC001);
    @(negedge clk); xferCh = 3'd4; #1;
    check("R9 channel 4 no shift", memAddr, 17'h0C001);
  endtask

  task automatic testCollide();
    logic [15:0] v;
    write16(8'h06, 16'h0100);
    ioWrite(8'h0C, 8'h00);
    @(negedge clk);
    ioAddr = 8'h06; ioWrData = 8'h77; ioWr = 1'b1;
    xferCh = 3'd3; xferValid = 1'b1;
    @(negedge clk);
    ioWr = 1'b0; xferValid = 1'b0;
    read16(8'h06, v);
    check("R10 write wins over step", {1'b0, v}, 17'h0177);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testResetDecode();
    testGroups();
    testClears();
    testNonAddr();
    testStep();
    testAutoInit();
    testCollide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule